// File: doc/BRIEF.md
# Enable-Width Rate-Detecting Serial Word Receiver

This block takes one serial voice-codec word per frame from three pins: a data clock, a frame enable and a data line. It gives back a parallel word. Nothing about the word is configured. The block counts the data-clock falling edges that occur while the enable is high, and that count alone sets two things for the frame. The first is whether the frame uses short framing or long framing. The second is which of four transcoding rates applies, and so how many bits make up the word. The block then collects that many bits, most significant first. It presents them left-justified in an 8-bit word, together with a 2-bit rate code and a one-cycle valid strobe.

All three pins pass through two-flop synchronisers into a free-running system clock, and edges are detected in that domain. The system clock must run at least four times faster than the data clock. A frame that cannot be classified produces an error pulse and no valid strobe, and so does a frame that a new enable cuts short. A change of framing mode between two delivered words corrupts data on the line. For that reason, the first word after such a change is marked as suspect.

Top module: `ewr_rx`

## Requirements
- R1: A synchronous active-high reset clears the held word, the rate code and the short flag to zero. It also removes any valid, error or suspect pulse and forgets the framing mode of earlier frames.
- R2: Two falling edges inside the enable select rate code 00. Those two bits form word bits [7:6], and bits [5:0] are zero.
- R3: Three falling edges inside the enable select rate code 01. Those three bits fill word bits [7:5].
- R4: Four falling edges inside the enable select rate code 10. Those four bits fill word bits [7:4].
- R5: Five to eight falling edges inside the enable select rate code 11 and an 8-bit word. When fewer than eight edges fall inside the enable, the remaining bits are taken on the falling edges that follow it, most significant bit first.
- R6: Exactly one falling edge inside the enable selects short framing. The bit sampled on that edge is discarded. The four bits on the next four falling edges fill word bits [7:4], the rate code is 10 and the short flag is 1.
- R7: A frame with zero falling edges inside the enable, or with more than eight, pulses the error output for one cycle. It gives no valid strobe and leaves the held word, rate code and short flag unchanged.
- R8: Each completed frame gives exactly one single-cycle valid pulse. The word, rate code and short flag change only in that cycle.
- R9: Suspect is high only together with valid. It is high when the framing mode of the delivered frame differs from that of the previous delivered frame since reset.
- R10: When a new enable rises while trailing bits are still owed, the open frame is dropped with an error pulse, and the new frame is received normally.
- R11: Rate and mode are decided anew for each enable, so consecutive frames may use different rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the data clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial data clock (asynchronous) |
| frame_en_i | input | 1 | Frame enable; a rising edge starts a word |
| ser_dat_i | input | 1 | Serial data, sampled on data-clock falling edges |
| word_o | output | 8 | Received word, left-justified, held between frames |
| rate_o | output | 2 | Rate code: 00=16, 01=24, 10=32, 11=64 kbps |
| short_o | output | 1 | Last delivered frame used short framing |
| valid_o | output | 1 | One-cycle strobe: new word delivered |
| err_o | output | 1 | One-cycle strobe: frame dropped |
| suspect_o | output | 1 | With valid: framing mode changed from previous word |

## Verification
The assertions take three things for granted. The enable never changes in the same system-clock cycle as a data-clock falling edge. Each data-clock level lasts at least two system-clock cycles. Data is stable around every falling edge. The stimulus changes data and enable only while the data clock is high, one cycle after its rising edge, and it holds each clock half-period for four system cycles. Under those conditions every edge and every bit survives synchronisation in its original order.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

  typedef enum logic [1:0] {
    RATE_16 = 2'b00,
    RATE_24 = 2'b01,
    RATE_32 = 2'b10,
    RATE_64 = 2'b11
  } rate_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_INEN = 2'b01,
    ST_TAIL = 2'b10
  } rx_state_t;

  // Edge counts inside the enable that select each framing / rate
  localparam int EDGES_SHORT = 1;
  localparam int EDGES_16    = 2;
  localparam int EDGES_24    = 3;
  localparam int EDGES_32    = 4;
  localparam int BITS_32     = 4;

endpackage

// File: rtl/ewr_sync_edge.sv
// Multi-bit two-flop (parameterised) synchroniser with registered edge history.
module ewr_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rose_o,
  output logic [N-1:0] fell_o
);

  logic [N-1:0] prev_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign lvl_o[b] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_o;
  end

  assign rose_o = lvl_o & ~prev_q;
  assign fell_o = ~lvl_o & prev_q;

endmodule

// File: rtl/ewr_classify.sv
// Maps the number of falling edges seen inside the enable to mode, rate and bit count.
module ewr_classify
  import ewr_pkg::*;
#(
  parameter int W    = 8,
  parameter int MAXE = 8,
  parameter int CW   = $clog2(MAXE + 2),
  parameter int GW   = $clog2(W + 1)
) (
  input  logic [CW-1:0] edges_i,
  output logic          ok_o,
  output logic          short_o,
  output rate_t         rate_o,
  output logic [GW-1:0] need_o
);

  always_comb begin
    ok_o    = 1'b1;
    short_o = 1'b0;
    rate_o  = RATE_64;
    need_o  = GW'(W);
    if (int'(edges_i) == EDGES_SHORT) begin
      short_o = 1'b1;
      rate_o  = RATE_32;
      need_o  = GW'(BITS_32);
    end else if (int'(edges_i) == EDGES_16) begin
      rate_o = RATE_16;
      need_o = GW'(EDGES_16);
    end else if (int'(edges_i) == EDGES_24) begin
      rate_o = RATE_24;
      need_o = GW'(EDGES_24);
    end else if (int'(edges_i) == EDGES_32) begin
      rate_o = RATE_32;
      need_o = GW'(EDGES_32);
    end else if (int'(edges_i) > EDGES_32 && int'(edges_i) <= MAXE) begin
      rate_o = RATE_64;
      need_o = GW'(W);
    end else begin
      ok_o = 1'b0;
    end
  end

endmodule

// File: rtl/ewr_collect.sv
// Frame state machine: counts enable width, collects bits, delivers the word.
module ewr_collect
  import ewr_pkg::*;
#(
  parameter int W    = 8,
  parameter int MAXE = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dclk_fell_i,
  input  logic         en_rose_i,
  input  logic         en_fell_i,
  input  logic         dat_i,
  output logic [W-1:0] word_o,
  output logic [1:0]   rate_o,
  output logic         short_o,
  output logic         valid_o,
  output logic         err_o,
  output logic         suspect_o
);

  localparam int CW  = $clog2(MAXE + 2);
  localparam int GW  = $clog2(W + 1);
  localparam int SAT = MAXE + 1;

  rx_state_t     state_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [GW-1:0] got_q, got_n, need_q;
  logic [W-1:0]  sh_q, sh_n;
  rate_t         rate_q;
  logic          shortf_q;
  logic          have_prev_q, prev_short_q;

  logic          c_ok, c_short;
  rate_t         c_rate;
  logic [GW-1:0] c_need;

  logic          fin_go, fin_err, fin_short;
  logic [GW-1:0] fin_need;
  rate_t         fin_rate;
  logic [W-1:0]  fin_word;

  assign cnt_n = (dclk_fell_i && cnt_q != CW'(SAT)) ? cnt_q + 1'b1 : cnt_q;
  assign got_n = dclk_fell_i ? got_q + 1'b1 : got_q;
  assign sh_n  = dclk_fell_i ? {sh_q[W-2:0], dat_i} : sh_q;

  ewr_classify #(.W(W), .MAXE(MAXE), .CW(CW), .GW(GW)) u_cls (
    .edges_i (cnt_n),
    .ok_o    (c_ok),
    .short_o (c_short),
    .rate_o  (c_rate),
    .need_o  (c_need)
  );

  // Completion / drop decision for this cycle
  always_comb begin
    fin_go    = 1'b0;
    fin_err   = 1'b0;
    fin_need  = need_q;
    fin_rate  = rate_q;
    fin_short = shortf_q;
    if (en_rose_i) begin
      fin_err = (state_q == ST_TAIL);
    end else begin
      unique case (state_q)
        ST_INEN: begin
          if (en_fell_i) begin
            if (!c_ok) begin
              fin_err = 1'b1;
            end else if (!c_short && got_n == c_need) begin
              fin_go    = 1'b1;
              fin_need  = c_need;
              fin_rate  = c_rate;
              fin_short = 1'b0;
            end
          end
        end
        ST_TAIL: begin
          if (dclk_fell_i && got_n == need_q) fin_go = 1'b1;
        end
        default: ;
      endcase
    end
    fin_word = sh_n << (W - int'(fin_need));
  end

  // Frame state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      got_q    <= '0;
      sh_q     <= '0;
      need_q   <= '0;
      rate_q   <= RATE_16;
      shortf_q <= 1'b0;
    end else if (en_rose_i) begin
      state_q <= ST_INEN;
      cnt_q   <= '0;
      got_q   <= '0;
      sh_q    <= '0;
    end else begin
      unique case (state_q)
        ST_INEN: begin
          cnt_q <= cnt_n;
          got_q <= got_n;
          sh_q  <= sh_n;
          if (en_fell_i) begin
            need_q   <= c_need;
            rate_q   <= c_rate;
            shortf_q <= c_short;
            if (!c_ok || fin_go) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_TAIL;
              if (c_short) begin
                got_q <= '0;
                sh_q  <= '0;
              end
            end
          end
        end
        ST_TAIL: begin
          got_q <= got_n;
          sh_q  <= sh_n;
          if (fin_go) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o       <= '0;
      rate_o       <= '0;
      short_o      <= 1'b0;
      valid_o      <= 1'b0;
      err_o        <= 1'b0;
      suspect_o    <= 1'b0;
      have_prev_q  <= 1'b0;
      prev_short_q <= 1'b0;
    end else begin
      valid_o   <= fin_go;
      err_o     <= fin_err;
      suspect_o <= fin_go && have_prev_q && (prev_short_q != fin_short);
      if (fin_go) begin
        word_o       <= fin_word;
        rate_o       <= fin_rate;
        short_o      <= fin_short;
        have_prev_q  <= 1'b1;
        prev_short_q <= fin_short;
      end
    end
  end

endmodule

// File: rtl/ewr_rx.sv
module ewr_rx #(
  parameter int W           = 8,
  parameter int MAXE        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk_i,
  input  logic         frame_en_i,
  input  logic         ser_dat_i,
  output logic [W-1:0] word_o,
  output logic [1:0]   rate_o,
  output logic         short_o,
  output logic         valid_o,
  output logic         err_o,
  output logic         suspect_o
);

  localparam int NPIN  = 3;
  localparam int P_CLK = 0;
  localparam int P_EN  = 1;
  localparam int P_DAT = 2;

  logic [NPIN-1:0] pin_lvl, pin_rose, pin_fell;

  ewr_sync_edge #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_dat_i, frame_en_i, ser_clk_i}),
    .lvl_o   (pin_lvl),
    .rose_o  (pin_rose),
    .fell_o  (pin_fell)
  );

  ewr_collect #(.W(W), .MAXE(MAXE)) u_col (
    .clk         (clk),
    .rst         (rst),
    .dclk_fell_i (pin_fell[P_CLK]),
    .en_rose_i   (pin_rose[P_EN]),
    .en_fell_i   (pin_fell[P_EN]),
    .dat_i       (pin_lvl[P_DAT]),
    .word_o      (word_o),
    .rate_o      (rate_o),
    .short_o     (short_o),
    .valid_o     (valid_o),
    .err_o       (err_o),
    .suspect_o   (suspect_o)
  );

endmodule

// File: rtl/ewr_rx_chk.sv
module ewr_rx_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] word_o,
  input logic [1:0]   rate_o,
  input logic         short_o,
  input logic         valid_o,
  input logic         err_o,
  input logic         suspect_o
);

  // R1: first cycle out of reset carries no strobe
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !err_o && !suspect_o));

  // R7: a dropped frame never also delivers
  a_r7_err_excl_valid: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);

  // R8: valid is a single-cycle pulse
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8: held outputs move only with valid
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(word_o) && $stable(rate_o) && $stable(short_o)));

  // R6: a short-framed word always reports rate code 10
  a_r6_short_rate: assert property (@(posedge clk) disable iff (rst)
    (valid_o && short_o) |-> (rate_o == 2'b10));

  // R9: suspect only accompanies a delivered word
  a_r9_suspect_with_valid: assert property (@(posedge clk) disable iff (rst)
    suspect_o |-> valid_o);

endmodule

bind ewr_rx ewr_rx_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_o    (word_o),
  .rate_o    (rate_o),
  .short_o   (short_o),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .suspect_o (suspect_o)
);

// File: tb/sim_ewr_rx.sv
`timescale 1ns/1ps
module sim_ewr_rx;

  localparam int H  = 4;   // system cycles per data-clock half period
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dclk = 1'b1, den = 1'b0, dat = 1'b0;
  logic [7:0] word_o;
  logic [1:0] rate_o;
  logic short_o, valid_o, err_o, suspect_o;

  int checks = 0, errors = 0;
  int nval = 0, nerr = 0;
  logic cap_susp = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ewr_rx u0 (
    .clk(clk), .rst(rst), .ser_clk_i(dclk), .frame_en_i(den), .ser_dat_i(dat),
    .word_o(word_o), .rate_o(rate_o), .short_o(short_o),
    .valid_o(valid_o), .err_o(err_o), .suspect_o(suspect_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin nval++; cap_susp = suspect_o; end
      if (err_o) nerr++;
    end
  end

  // {n_in[4], n_tail[4], bits[8], e_val, e_err, e_rate[2], e_word[8], e_short, e_susp}
  localparam logic [29:0] VEC [NV] = '{
    {4'd2, 4'd0, 8'h80, 1'b1, 1'b0, 2'b00, 8'h80, 1'b0, 1'b0},
    {4'd3, 4'd0, 8'hA0, 1'b1, 1'b0, 2'b01, 8'hA0, 1'b0, 1'b0},
    {4'd4, 4'd0, 8'h50, 1'b1, 1'b0, 2'b10, 8'h50, 1'b0, 1'b0},
    {4'd8, 4'd0, 8'h96, 1'b1, 1'b0, 2'b11, 8'h96, 1'b0, 1'b0},
    {4'd5, 4'd3, 8'h3C, 1'b1, 1'b0, 2'b11, 8'h3C, 1'b0, 1'b0},
    {4'd1, 4'd4, 8'hB0, 1'b1, 1'b0, 2'b10, 8'h60, 1'b1, 1'b1},
    {4'd1, 4'd4, 8'h68, 1'b1, 1'b0, 2'b10, 8'hD0, 1'b1, 1'b0},
    {4'd4, 4'd0, 8'hF0, 1'b1, 1'b0, 2'b10, 8'hF0, 1'b0, 1'b1},
    {4'd0, 4'd0, 8'h00, 1'b0, 1'b1, 2'b10, 8'hF0, 1'b0, 1'b0},
    {4'd9, 4'd0, 8'hFF, 1'b0, 1'b1, 2'b10, 8'hF0, 1'b0, 1'b0},
    {4'd6, 4'd2, 8'h5A, 1'b1, 1'b0, 2'b11, 8'h5A, 1'b0, 1'b0},
    {4'd2, 4'd0, 8'h40, 1'b1, 1'b0, 2'b00, 8'h40, 1'b0, 1'b0}
  };
  string tag [NV] = '{"R2", "R3", "R4", "R5", "R5", "R6", "R6", "R9", "R7", "R7", "R11", "R11"};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int n_in, input int n_tail, input logic [7:0] bits);
    den = 1'b1;
    repeat (2) @(negedge clk);
    if (n_in == 0) begin
      repeat (H) @(negedge clk);
      den = 1'b0;
    end
    for (int i = 0; i < n_in + n_tail; i++) begin
      dat = (i < 8) ? bits[7-i] : 1'b0;
      repeat (H) @(negedge clk);
      dclk = 1'b0;
      repeat (H) @(negedge clk);
      dclk = 1'b1;
      if (i == n_in - 1) begin
        @(negedge clk);
        den = 1'b0;
      end
    end
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(word_o == 8'h00, "R1", "word", word_o, 0);
    chk(rate_o == 2'b00 && !short_o, "R1", "rate/short", {rate_o, short_o}, 0);
    chk(!valid_o && !err_o && !suspect_o, "R1", "strobes", {valid_o, err_o, suspect_o}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [29:0] e;
      e = VEC[v];
      nval = 0; nerr = 0;
      send(int'(e[29:26]), int'(e[25:22]), e[21:14]);
      chk(nval == int'(e[13]), "R8", {tag[v], " valid count"}, nval, int'(e[13]));
      chk(nerr == int'(e[12]), tag[v], "error count", nerr, int'(e[12]));
      chk(rate_o == e[11:10], tag[v], "rate", rate_o, e[11:10]);
      chk(word_o == e[9:2], tag[v], "word", word_o, e[9:2]);
      chk(short_o == e[1], tag[v], "short", short_o, e[1]);
      if (e[13]) chk(cap_susp == e[0], tag[v], "suspect", cap_susp, e[0]);
    end

    // R10: new enable while trailing bits are owed
    nval = 0; nerr = 0;
    send(5, 1, 8'hFF);
    chk(nval == 0, "R10", "valid on open frame", nval, 0);
    send(2, 0, 8'hC0);
    chk(nerr == 1, "R10", "abort error", nerr, 1);
    chk(nval == 1, "R10", "next frame valid", nval, 1);
    chk(word_o == 8'hC0 && rate_o == 2'b00, "R10", "next frame word/rate",
        {word_o, rate_o}, {8'hC0, 2'b00});

    // R1: mid-run reset clears held outputs and mode history
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(word_o == 8'h00 && rate_o == 2'b00 && !short_o, "R1", "held outputs after reset",
        {word_o, rate_o, short_o}, 0);
    nval = 0; nerr = 0;
    send(1, 4, 8'h70);
    chk(nval == 1 && word_o == 8'hE0 && short_o, "R6", "short after reset",
        {word_o, short_o}, {8'hE0, 1'b1});
    chk(cap_susp == 1'b0, "R1", "no suspect after reset", cap_susp, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule